// File: doc/BRIEF.md
# Predicated Vector Load/Store Address Sequencer

This block expands a single load or store instruction into a series of per-element memory requests. A start pulse captures the whole operation: the element count, the base value, either an index value (indexed form) or a signed displacement (immediate form), the access size, one flag each for whether the source side and the destination side are vectors, a stride selector for the immediate form, and two independent predicate masks, one per side. After that, the block issues one request per element. Each request carries an effective address, a source element number and a destination element number. Requests use a valid/ready handshake, and a one-cycle done pulse closes the operation.

Each side steps through its own element numbers and skips the elements whose predicate bit is clear. A side flagged as scalar stays at element 0 and ignores its mask. The sequence ends as soon as either side runs past the element count, so source and destination may pair up elements at different positions. When both sides are scalar, exactly one request is issued.

The controller is a four-state machine. IDLE waits for start; the transition IDLE→SKIP loads the operation. SKIP moves each vector side past its masked-out elements, one element per side per cycle. From SKIP, the transition SKIP→ISSUE fires when both sides are on a live element, and SKIP→DONE fires when either side is out of range. ISSUE presents the request. On acceptance it takes ISSUE→SKIP, or ISSUE→DONE when both sides are scalar. DONE raises the done pulse and returns to IDLE through DONE→IDLE.

Top module: `vec_ldst_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, req_valid_o and done_o are low.
- R2: With indexed_i high, every request address is base_i + index_i, taken modulo 2^64.
- R3: With indexed_i low and elem_stride_i low (unit stride), the address is base_i + sign-extended disp_i + src_idx × size. The size code width_i maps 0, 1, 2, 3 to 1, 2, 4, 8 bytes.
- R4: With indexed_i low and elem_stride_i high (element stride), the address is base_i + src_idx × sign-extended disp_i.
- R5: On a vector side, an element whose mask bit is 0 is never issued. Bit i of a mask governs element i, and the two sides skip independently of each other.
- R6: A scalar side always reports element 0 and ignores its mask. When both sides are scalar, exactly one request is issued.
- R7: Requests continue only while both element numbers are below the element count. A count of 0 issues no request. A count above 64 is treated as 64.
- R8: While req_valid_o is high and req_ready_i is low, the request stays valid and its address and both element numbers do not change.
- R9: done_o is high for exactly one cycle per operation, after the last accepted request or after the skip phase when nothing qualifies. It is never high together with req_valid_o.
- R10: A start pulse is ignored while an operation is in progress; the running sequence is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation (taken only in IDLE) |
| vl_i | input | 7 | Element count, 0..64 |
| base_i | input | 64 | Base register value |
| index_i | input | 64 | Index register value (indexed form) |
| disp_i | input | 16 | Signed displacement (immediate form) |
| indexed_i | input | 1 | 1 = indexed form, 0 = immediate form |
| elem_stride_i | input | 1 | Immediate form: 0 = unit stride, 1 = element stride |
| width_i | input | 2 | Size code: 0=1 B, 1=2 B, 2=4 B, 3=8 B |
| src_vec_i | input | 1 | Source side is a vector |
| dst_vec_i | input | 1 | Destination side is a vector |
| src_mask_i | input | 64 | Source predicate, bit i for element i |
| dst_mask_i | input | 64 | Destination predicate, bit i for element i |
| req_valid_o | output | 1 | Request present |
| req_ready_i | input | 1 | Consumer accepts the request |
| req_addr_o | output | 64 | Effective address |
| req_src_idx_o | output | 7 | Source element number |
| req_dst_idx_o | output | 7 | Destination element number |
| done_o | output | 1 | One-cycle end-of-operation pulse |

## Verification
The two functions that coincide are the source-side skip and the destination-side skip. Both advance in the same SKIP cycle whenever each side sits on a masked-out element. The sweep provokes this with mask pairs whose holes sometimes line up and sometimes are offset, so one side waits on a live element while the other is still skipping. The outcome is judged from the complete request sequence, compared entry by entry against an arithmetic model. That model walks the two masks exactly as R5–R7 describe, under random back-pressure on ready.

// File: rtl/vls_pkg.sv
package vls_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SKIP,
        ST_ISSUE,
        ST_DONE
    } vls_state_e;

    localparam int SIDE_SRC = 0;
    localparam int SIDE_DST = 1;
    localparam int NUM_SIDES = 2;

endpackage

// File: rtl/vls_walker.sv
module vls_walker #(
    parameter int MAX_VL = 64,
    parameter int VL_W   = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              skip_i,
    input  logic              step_i,
    input  logic              is_vec_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic [MAX_VL-1:0] mask_i,
    output logic [VL_W-1:0]   idx_o,
    output logic              ok_o,
    output logic              exh_o
);
    localparam int MIW = $clog2(MAX_VL);

    logic [VL_W-1:0] idx_q;
    logic            bit_live;

    assign exh_o    = (idx_q >= vl_i);
    assign bit_live = mask_i[idx_q[MIW-1:0]];
    assign ok_o     = !is_vec_i || exh_o || bit_live;
    assign idx_o    = idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            idx_q <= '0;
        end else if (skip_i && is_vec_i && !exh_o && !bit_live) begin
            idx_q <= idx_q + 1'b1;
        end else if (step_i && is_vec_i) begin
            idx_q <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/vls_addr_gen.sv
module vls_addr_gen #(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 16,
    parameter int VL_W   = 7
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] index_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic              indexed_i,
    input  logic              elem_stride_i,
    input  logic [1:0]        width_i,
    input  logic [VL_W-1:0]   src_idx_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] sdisp;
    logic [ADDR_W-1:0] idx_ext;
    logic [ADDR_W-1:0] unit_off;
    logic [ADDR_W-1:0] elem_off;

    assign sdisp    = {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
    assign idx_ext  = {{(ADDR_W-VL_W){1'b0}}, src_idx_i};
    assign unit_off = sdisp + (idx_ext << width_i);
    assign elem_off = idx_ext * sdisp;

    always_comb begin
        if (indexed_i) begin
            addr_o = base_i + index_i;
        end else if (elem_stride_i) begin
            addr_o = base_i + elem_off;
        end else begin
            addr_o = base_i + unit_off;
        end
    end
endmodule

// File: rtl/vls_ctrl.sv
module vls_ctrl
    import vls_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic src_ok_i,
    input  logic dst_ok_i,
    input  logic src_exh_i,
    input  logic dst_exh_i,
    input  logic both_scalar_i,
    input  logic ready_i,
    output logic load_o,
    output logic skip_o,
    output logic step_o,
    output logic valid_o,
    output logic done_o
);
    vls_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_SKIP;
            end
            ST_SKIP: begin
                if (src_exh_i || dst_exh_i) begin
                    state_d = ST_DONE;
                end else if (src_ok_i && dst_ok_i) begin
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (ready_i) begin
                    state_d = both_scalar_i ? ST_DONE : ST_SKIP;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_o  = 1'b0;
        skip_o  = 1'b0;
        step_o  = 1'b0;
        valid_o = 1'b0;
        done_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:  load_o  = start_i;
            ST_SKIP:  skip_o  = 1'b1;
            ST_ISSUE: begin
                valid_o = 1'b1;
                step_o  = ready_i;
            end
            ST_DONE:  done_o  = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/vec_ldst_seq.sv
module vec_ldst_seq
    import vls_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 16,
    parameter int MAX_VL = 64,
    parameter int VL_W   = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] index_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic              indexed_i,
    input  logic              elem_stride_i,
    input  logic [1:0]        width_i,
    input  logic              src_vec_i,
    input  logic              dst_vec_i,
    input  logic [MAX_VL-1:0] src_mask_i,
    input  logic [MAX_VL-1:0] dst_mask_i,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [VL_W-1:0]   req_src_idx_o,
    output logic [VL_W-1:0]   req_dst_idx_o,
    output logic              done_o
);
    localparam logic [VL_W-1:0] VL_CAP = VL_W'(MAX_VL);

    logic              load, skip, step;
    logic [ADDR_W-1:0] base_q, index_q;
    logic [DISP_W-1:0] disp_q;
    logic              indexed_q, elem_stride_q;
    logic [1:0]        width_q;
    logic [VL_W-1:0]   vl_q;
    logic              src_vec_q, dst_vec_q;
    logic [MAX_VL-1:0] src_mask_q, dst_mask_q;

    logic [NUM_SIDES-1:0]            side_vec, side_ok, side_exh;
    logic [NUM_SIDES-1:0][MAX_VL-1:0] side_mask;
    logic [NUM_SIDES-1:0][VL_W-1:0]  side_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q        <= '0;
            index_q       <= '0;
            disp_q        <= '0;
            indexed_q     <= 1'b0;
            elem_stride_q <= 1'b0;
            width_q       <= '0;
            vl_q          <= '0;
            src_vec_q     <= 1'b0;
            dst_vec_q     <= 1'b0;
            src_mask_q    <= '0;
            dst_mask_q    <= '0;
        end else if (load) begin
            base_q        <= base_i;
            index_q       <= index_i;
            disp_q        <= disp_i;
            indexed_q     <= indexed_i;
            elem_stride_q <= elem_stride_i;
            width_q       <= width_i;
            vl_q          <= (vl_i > VL_CAP) ? VL_CAP : vl_i;
            src_vec_q     <= src_vec_i;
            dst_vec_q     <= dst_vec_i;
            src_mask_q    <= src_mask_i;
            dst_mask_q    <= dst_mask_i;
        end
    end

    assign side_vec[SIDE_SRC]  = src_vec_q;
    assign side_vec[SIDE_DST]  = dst_vec_q;
    assign side_mask[SIDE_SRC] = src_mask_q;
    assign side_mask[SIDE_DST] = dst_mask_q;

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        vls_walker #(
            .MAX_VL (MAX_VL),
            .VL_W   (VL_W)
        ) u_walk (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear_i  (load),
            .skip_i   (skip),
            .step_i   (step),
            .is_vec_i (side_vec[g]),
            .vl_i     (vl_q),
            .mask_i   (side_mask[g]),
            .idx_o    (side_idx[g]),
            .ok_o     (side_ok[g]),
            .exh_o    (side_exh[g])
        );
    end

    vls_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .src_ok_i      (side_ok[SIDE_SRC]),
        .dst_ok_i      (side_ok[SIDE_DST]),
        .src_exh_i     (side_exh[SIDE_SRC]),
        .dst_exh_i     (side_exh[SIDE_DST]),
        .both_scalar_i (!src_vec_q && !dst_vec_q),
        .ready_i       (req_ready_i),
        .load_o        (load),
        .skip_o        (skip),
        .step_o        (step),
        .valid_o       (req_valid_o),
        .done_o        (done_o)
    );

    vls_addr_gen #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W),
        .VL_W   (VL_W)
    ) u_addr (
        .base_i        (base_q),
        .index_i       (index_q),
        .disp_i        (disp_q),
        .indexed_i     (indexed_q),
        .elem_stride_i (elem_stride_q),
        .width_i       (width_q),
        .src_idx_i     (side_idx[SIDE_SRC]),
        .addr_o        (req_addr_o)
    );

    assign req_src_idx_o = side_idx[SIDE_SRC];
    assign req_dst_idx_o = side_idx[SIDE_DST];
endmodule

// File: rtl/vls_checker.sv
module vls_checker #(
    parameter int ADDR_W = 64,
    parameter int MAX_VL = 64,
    parameter int VL_W   = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_o,
    input logic              req_ready_i,
    input logic [ADDR_W-1:0] req_addr_o,
    input logic [VL_W-1:0]   req_src_idx_o,
    input logic [VL_W-1:0]   req_dst_idx_o,
    input logic              done_o,
    input logic              src_vec_q,
    input logic              dst_vec_q,
    input logic [VL_W-1:0]   vl_q,
    input logic [MAX_VL-1:0] src_mask_q,
    input logic [MAX_VL-1:0] dst_mask_q
);
    localparam int MIW = $clog2(MAX_VL);

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o)
            && $stable(req_src_idx_o) && $stable(req_dst_idx_o));

    // R9
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !req_valid_o);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    scalar_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && !src_vec_q |-> req_src_idx_o == '0);

    // R6
    scalar_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && !dst_vec_q |-> req_dst_idx_o == '0);

    // R7
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (req_src_idx_o < vl_q) && (req_dst_idx_o < vl_q));

    // R5
    src_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && src_vec_q |-> src_mask_q[req_src_idx_o[MIW-1:0]]);

    // R5
    dst_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && dst_vec_q |-> dst_mask_q[req_dst_idx_o[MIW-1:0]]);
endmodule

bind vec_ldst_seq vls_checker #(
    .ADDR_W (ADDR_W),
    .MAX_VL (MAX_VL),
    .VL_W   (VL_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid_o   (req_valid_o),
    .req_ready_i   (req_ready_i),
    .req_addr_o    (req_addr_o),
    .req_src_idx_o (req_src_idx_o),
    .req_dst_idx_o (req_dst_idx_o),
    .done_o        (done_o),
    .src_vec_q     (src_vec_q),
    .dst_vec_q     (dst_vec_q),
    .vl_q          (vl_q),
    .src_mask_q    (src_mask_q),
    .dst_mask_q    (dst_mask_q)
);

// File: tb/tb_vec_ldst_seq.sv
module tb_vec_ldst_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [6:0]  vl_i;
    logic [63:0] base_i, index_i;
    logic [15:0] disp_i;
    logic        indexed_i, elem_stride_i;
    logic [1:0]  width_i;
    logic        src_vec_i, dst_vec_i;
    logic [63:0] src_mask_i, dst_mask_i;
    logic        req_valid_o, req_ready_i;
    logic [63:0] req_addr_o;
    logic [6:0]  req_src_idx_o, req_dst_idx_o;
    logic        done_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [63:0] exp_addr [64];
    logic [6:0]  exp_s    [64];
    logic [6:0]  exp_d    [64];
    int          exp_n;

    always #5 clk = ~clk;

    vec_ldst_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i),
        .base_i(base_i), .index_i(index_i), .disp_i(disp_i),
        .indexed_i(indexed_i), .elem_stride_i(elem_stride_i), .width_i(width_i),
        .src_vec_i(src_vec_i), .dst_vec_i(dst_vec_i),
        .src_mask_i(src_mask_i), .dst_mask_i(dst_mask_i),
        .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
        .req_addr_o(req_addr_o), .req_src_idx_o(req_src_idx_o),
        .req_dst_idx_o(req_dst_idx_o), .done_o(done_o)
    );

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected finished)");
        report();
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Reference walk of R2..R7
    task automatic build_expect(input int vl, input int w, input int mode,
                                input bit sv, input bit dv,
                                input logic [63:0] sm, input logic [63:0] dm,
                                input logic [63:0] base, input logic [63:0] idx,
                                input logic [15:0] disp);
        int i = 0;
        int j = 0;
        logic [63:0] sd;
        sd = {{48{disp[15]}}, disp};
        if (vl > 64) vl = 64;
        exp_n = 0;
        while (i < vl && j < vl) begin
            if (sv) while (i < vl && !sm[i]) i++;
            if (dv) while (j < vl && !dm[j]) j++;
            if (i >= vl || j >= vl) break;
            if (mode == 0)      exp_addr[exp_n] = base + idx;
            else if (mode == 1) exp_addr[exp_n] = base + sd + (64'(i) << w);
            else                exp_addr[exp_n] = base + 64'(i) * sd;
            exp_s[exp_n] = 7'(i);
            exp_d[exp_n] = 7'(j);
            exp_n++;
            if (!sv && !dv) break;
            if (sv) i++;
            if (dv) j++;
        end
    endtask

    task automatic run_case(input int vl, input int w, input int mode,
                            input bit sv, input bit dv,
                            input logic [63:0] sm, input logic [63:0] dm,
                            input logic [63:0] base, input logic [63:0] idx,
                            input logic [15:0] disp, input bit hold_start);
        int k = 0;
        int dones = 0;
        int cyc = 0;
        bit prev_stall = 0;
        logic [63:0] pa;
        logic [6:0] ps, pd;
        string rq;
        rq = (mode == 0) ? "R2" : (mode == 1) ? "R3" : "R4";
        build_expect(vl, w, mode, sv, dv, sm, dm, base, idx, disp);
        @(negedge clk);
        vl_i = 7'(vl); width_i = 2'(w); indexed_i = (mode == 0);
        elem_stride_i = (mode == 2); src_vec_i = sv; dst_vec_i = dv;
        src_mask_i = sm; dst_mask_i = dm; base_i = base; index_i = idx;
        disp_i = disp; start_i = 1'b1;
        while (dones == 0 && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (!hold_start) start_i = 1'b0;
            // change the operands after capture: must not matter
            base_i = ~base; src_mask_i = ~sm; vl_i = 7'd3;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            req_ready_i = lfsr[0] | lfsr[3];
            #1;
            if (prev_stall) begin
                // R8 held request
                check(req_valid_o && req_addr_o == pa && req_src_idx_o == ps
                      && req_dst_idx_o == pd, "R8 stall hold", req_addr_o, pa);
            end
            prev_stall = req_valid_o && !req_ready_i;
            pa = req_addr_o; ps = req_src_idx_o; pd = req_dst_idx_o;
            if (req_valid_o && req_ready_i) begin
                if (k < exp_n) begin
                    check(req_addr_o == exp_addr[k], rq, req_addr_o, exp_addr[k]);
                    // R5 R6 element numbers on both sides
                    check(req_src_idx_o == exp_s[k] && req_dst_idx_o == exp_d[k],
                          "R5/R6 idx", {50'd0, req_src_idx_o, req_dst_idx_o},
                          {50'd0, exp_s[k], exp_d[k]});
                end
                k++;
            end
            if (done_o) begin
                dones++;
                check(!req_valid_o, "R9 done with valid", 64'(req_valid_o), 64'd0);
                start_i = 1'b0;
            end
        end
        // R7 and R10: number of requests matches the model
        check(k == exp_n, hold_start ? "R10 count" : "R7 count", 64'(k), 64'(exp_n));
        check(dones == 1, "R9 done seen", 64'(dones), 64'd1);
        @(negedge clk);
        #1;
        check(!done_o, "R9 pulse width", 64'(done_o), 64'd0);
        req_ready_i = 1'b0;
    endtask

    initial begin
        logic [63:0] smp [3];
        logic [63:0] dmp [3];
        int vls [4];
        smp[0] = '1;                     dmp[0] = '1;
        smp[1] = 64'h5555_5555_5555_5555; dmp[1] = 64'hF0F0_F0F0_F0F0_F0F0;
        smp[2] = 64'hFFFF_0000_0000_0006; dmp[2] = 64'h0000_0000_0000_00A9;
        vls[0] = 0; vls[1] = 1; vls[2] = 7; vls[3] = 64;
        rst_n = 1'b0; start_i = 1'b0; req_ready_i = 1'b0;
        vl_i = '0; base_i = '0; index_i = '0; disp_i = '0; indexed_i = 0;
        elem_stride_i = 0; width_i = '0; src_vec_i = 0; dst_vec_i = 0;
        src_mask_i = '0; dst_mask_i = '0;
        repeat (3) @(negedge clk);
        check(!req_valid_o && !done_o, "R1 in reset", {req_valid_o, done_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!req_valid_o && !done_o, "R1 after reset", {req_valid_o, done_o}, 64'd0);
        for (int w = 0; w < 4; w++)
            for (int m = 0; m < 3; m++)
                for (int f = 0; f < 4; f++)
                    for (int p = 0; p < 3; p++)
                        for (int v = 0; v < 4; v++)
                            run_case(vls[v], w, m, f[0], f[1], smp[p], dmp[p],
                                     64'h0000_1000_0000_0000 + 64'(w * 64'h40),
                                     64'hFFFF_FFFF_FFFF_FF00 + 64'(p),
                                     (p == 1) ? 16'hFFE8 : 16'h0028, 1'b0);
        // R7 count above 64 clamps
        run_case(100, 3, 1, 1, 1, smp[1], dmp[0], 64'h2000, 64'h0, 16'h0008, 1'b0);
        // R10 start held high throughout
        run_case(64, 2, 2, 1, 1, smp[2], dmp[1], 64'h3000, 64'h0, 16'hFFF0, 1'b1);
        // R6 both scalar with empty masks: one request
        run_case(9, 0, 1, 0, 0, 64'h0, 64'h0, 64'h4000, 64'h0, 16'h0005, 1'b0);
        report();
    end
endmodule